// File: doc/BRIEF.md
# Timer Compare/Capture Channel

A single 16-bit timer channel built around a free-running up-counter and one general register. A 3-bit mode field decides what the general register is for. In the four compare modes it is compared with the counter every cycle, and a match can set a sticky flag. Depending on the mode, a match can also drive an output pin low, drive it high or toggle it. In the four capture modes the register instead latches the counter value when a selected edge arrives on an input pin. The input pin passes through a synchroniser first.

An 8-bit status byte holds two sticky flags. One is for a match or a capture and the other is for counter wrap. Each flag is gated by an enable bit into its own interrupt line. Software clears a flag only by reading it as one and then writing zero to that bit. A build-time option turns toggle into a forced high level for channels that cannot toggle. A second option picks whether the top status bit resets to one or to zero.

All state is reached through a small register port, with a write strobe, a read strobe, a 3-bit address and combinational read data. The addresses are: 0 mode field (bits 2:0), 1 interrupt enables, 2 status byte, 3 counter, 4 general register. In the enable register and the status byte, bit 0 belongs to the match/capture flag and bit 1 to the wrap flag.

Top module: `tmr_chan_top`

## Requirements
- R1: After reset the mode field is 000, the enables are 0, the general register is 0xFFFF, the output pin is 0 with its enable low, and the counter starts from 0 (it reads 1 one clock after reset is released).
- R2: The counter adds one on every clock unless written; a write loads the value at the next edge. Going from 0xFFFF to 0x0000 sets the wrap flag (status bit 1) at the edge where the counter becomes zero.
- R3: A match is the cycle in which a compare mode is selected and the counter equals the general register. At the following edge, mode 001 drives the pin to 0, mode 010 drives it to 1, mode 011 inverts it, and mode 000 leaves it unchanged. The pin enable is high only in modes 001, 010 and 011.
- R4: A match sets the match/capture flag (status bit 0) in every compare mode, including 000.
- R5: On a channel built without toggle, mode 011 drives the pin to 1 on every match.
- R6: Mode 100 captures on a rising input edge, 101 on a falling edge, and 110 or 111 on either edge. A capture stores the counter value of the cycle in which the synchronised edge is seen, which is the counter value when the input changed plus two. A capture sets status bit 0.
- R7: In capture modes a counter match sets no flag and the pin enable is low. In compare modes, input edges leave the general register unchanged.
- R8: Writing 0 to a status flag clears it only if the flag was read as 1 earlier. A clear write without a prior read, and a write of 1, leave the flag unchanged.
- R9: If hardware sets a flag in the same cycle as a valid clear, the flag stays set.
- R10: Interrupt output irq_match is high when status bit 0 and enable bit 0 are both set. Interrupt output irq_wrap is high when status bit 1 and enable bit 1 are both set.
- R11: Status bits 6 to 3 read as one and bit 2 reads as zero. Bit 7 reads as one by default, so the byte resets to 0xF8; when the top-bit option is off it resets to 0x78.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; arms status flags for clearing |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| tio_in | input | 1 | Capture input pin (asynchronous) |
| tio_out | output | 1 | Compare output pin level |
| tio_oe | output | 1 | Compare output pin enable |
| irq_match | output | 1 | Match/capture interrupt request |
| irq_wrap | output | 1 | Counter wrap interrupt request |

## Verification
The properties check the rules that hold every cycle: the counter steps by one and returns to zero after a wrap, the pin moves only after a match, and the general register changes only on a write or a capture. They also check that a set flag survives a clear in the same cycle, and that a flag falls only after an armed clear. The bench scenarios show what only a particular order of stimulus can reveal. These are the exact pin level for each compare mode, the no-toggle variant, which edge each capture mode accepts, and the captured value two cycles behind the input change. They also cover the read-then-write clear protocol and the interrupt gating.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned NFLAG  = 2;
    localparam int unsigned STAT_W = 8;

    // flag positions inside the status byte and enable register
    localparam int unsigned FL_GEN = 0;
    localparam int unsigned FL_WRP = 1;

    // register addresses
    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_GREG = 3'd4;

    typedef enum logic [2:0] {
        IO_OFF      = 3'b000,
        IO_LOW      = 3'b001,
        IO_HIGH     = 3'b010,
        IO_TGL      = 3'b011,
        IO_CAP_RISE = 3'b100,
        IO_CAP_FALL = 3'b101,
        IO_CAP_ANY  = 3'b110,
        IO_CAP_ANY2 = 3'b111
    } iomode_e;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    localparam int unsigned TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_st_t;

    sync_st_t sync_d, sync_q;
    logic [STAGES-1:0] chain_nxt;

    assign chain_nxt[0] = pin_i;
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        assign chain_nxt[s] = sync_q.chain[s-1];
    end

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = chain_nxt;
        sync_d.last  = sync_q.chain[TOP];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rise_o = sync_q.chain[TOP] & ~sync_q.last;
    assign fall_o = ~sync_q.chain[TOP] & sync_q.last;

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld_i) begin
            cnt_d.cnt = ld_val_i;
        end else begin
            cnt_d.cnt = cnt_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o  = cnt_q.cnt;
    assign wrap_o = !ld_i && (cnt_q.cnt == CNT_MAX);

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ld_i |=> cnt_o == $past(cnt_o) + CNT_ONE); // R2

    AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> cnt_o == '0); // R2

endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
    parameter int unsigned NF      = 2,
    parameter int unsigned SW      = 8,
    parameter bit          TOP_ONE = 1'b1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [NF-1:0] set_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [NF-1:0] wdat_i,
    input  logic [NF-1:0] en_i,
    output logic [NF-1:0] irq_o,
    output logic [SW-1:0] stat_o
);

    localparam logic [SW-1:0] FIXED_ONES =
        {TOP_ONE, {(SW-4){1'b1}}, 3'b000};

    typedef struct packed {
        logic [NF-1:0] flag;
        logic [NF-1:0] arm;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic [NF-1:0] flag_nxt;
    logic [NF-1:0] arm_nxt;
    logic [NF-1:0] clr_ok;

    for (genvar k = 0; k < NF; k++) begin : g_flag
        assign clr_ok[k]   = wr_i && !wdat_i[k] && st_q.arm[k];
        assign flag_nxt[k] = set_i[k] | (st_q.flag[k] & ~clr_ok[k]);
        assign arm_nxt[k]  = flag_nxt[k] && !clr_ok[k] &&
                             (st_q.arm[k] || (rd_i && st_q.flag[k]));

        AST_CLR_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(st_q.flag[k]) |-> $past(st_q.arm[k] && wr_i && !wdat_i[k])); // R8
    end

    always_comb begin
        st_d      = st_q;
        st_d.flag = flag_nxt;
        st_d.arm  = arm_nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o  = st_q.flag & en_i;
    assign stat_o = FIXED_ONES | {{(SW-NF){1'b0}}, st_q.flag};

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|set_i) |=> ((st_q.flag & $past(set_i)) == $past(set_i))); // R9

endmodule

// File: rtl/tmr_chan_top.sv
module tmr_chan_top #(
    parameter int unsigned CNT_W        = 16,
    parameter bit          NO_TOGGLE    = 1'b0,
    parameter bit          STAT_TOP_ONE = 1'b1,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             tio_in,
    output logic             tio_out,
    output logic             tio_oe,
    output logic             irq_match,
    output logic             irq_wrap
);

    import tmr_pkg::*;

    localparam logic [CNT_W-1:0] GREG_RST = '1;
    localparam int unsigned      PAD_MODE = CNT_W - 3;
    localparam int unsigned      PAD_IEN  = CNT_W - NFLAG;
    localparam int unsigned      PAD_STAT = CNT_W - STAT_W;

    typedef struct packed {
        iomode_e          mode;
        logic [NFLAG-1:0] ien;
        logic [CNT_W-1:0] greg;
        logic             tout;
    } chan_st_t;

    chan_st_t ch_d, ch_q;

    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic              edge_rise;
    logic              edge_fall;
    logic              cap_mode;
    logic              cap_fire;
    logic              hit;
    logic              tgl_val;
    logic              ctrl_wr;
    logic              ien_wr;
    logic              stat_wr;
    logic              stat_rd;
    logic              cnt_wr;
    logic              greg_wr;
    logic [NFLAG-1:0]  flag_set;
    logic [NFLAG-1:0]  irq_vec;
    logic [STAT_W-1:0] stat_byte;

    // register port decode
    assign ctrl_wr = reg_wr && (reg_addr == ADR_CTRL);
    assign ien_wr  = reg_wr && (reg_addr == ADR_IEN);
    assign stat_wr = reg_wr && (reg_addr == ADR_STAT);
    assign cnt_wr  = reg_wr && (reg_addr == ADR_CNT);
    assign greg_wr = reg_wr && (reg_addr == ADR_GREG);
    assign stat_rd = reg_rd && (reg_addr == ADR_STAT);

    tmr_counter #(
        .W (CNT_W)
    ) u_cnt (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .ld_i     (cnt_wr),
        .ld_val_i (reg_wdata),
        .cnt_o    (cnt),
        .wrap_o   (wrap)
    );

    tmr_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .pin_i  (tio_in),
        .rise_o (edge_rise),
        .fall_o (edge_fall)
    );

    // capture edge selection and compare match
    assign cap_mode = ch_q.mode[2];

    always_comb begin
        cap_fire = 1'b0;
        unique case (ch_q.mode)
            IO_CAP_RISE: cap_fire = edge_rise;
            IO_CAP_FALL: cap_fire = edge_fall;
            IO_CAP_ANY,
            IO_CAP_ANY2: cap_fire = edge_rise | edge_fall;
            default:     cap_fire = 1'b0;
        endcase
    end

    assign hit = !cap_mode && (cnt == ch_q.greg);

    // channel variant: toggle capability or forced high
    if (NO_TOGGLE) begin : g_no_tgl
        assign tgl_val = 1'b1;
    end else begin : g_tgl
        assign tgl_val = ~ch_q.tout;
    end

    always_comb begin
        ch_d = ch_q;
        if (ctrl_wr) begin
            ch_d.mode = iomode_e'(reg_wdata[2:0]);
        end
        if (ien_wr) begin
            ch_d.ien = reg_wdata[NFLAG-1:0];
        end
        if (cap_fire) begin
            ch_d.greg = cnt;
        end else if (greg_wr) begin
            ch_d.greg = reg_wdata;
        end
        if (hit) begin
            unique case (ch_q.mode)
                IO_LOW:  ch_d.tout = 1'b0;
                IO_HIGH: ch_d.tout = 1'b1;
                IO_TGL:  ch_d.tout = tgl_val;
                default: ch_d.tout = ch_q.tout;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q      <= '0;
            ch_q.mode <= IO_OFF;
            ch_q.greg <= GREG_RST;
        end else begin
            ch_q <= ch_d;
        end
    end

    // status flags and interrupt gating
    always_comb begin
        flag_set         = '0;
        flag_set[FL_GEN] = hit | cap_fire;
        flag_set[FL_WRP] = wrap;
    end

    tmr_status #(
        .NF      (NFLAG),
        .SW      (STAT_W),
        .TOP_ONE (STAT_TOP_ONE)
    ) u_stat (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .set_i  (flag_set),
        .rd_i   (stat_rd),
        .wr_i   (stat_wr),
        .wdat_i (reg_wdata[NFLAG-1:0]),
        .en_i   (ch_q.ien),
        .irq_o  (irq_vec),
        .stat_o (stat_byte)
    );

    assign irq_match = irq_vec[FL_GEN];
    assign irq_wrap  = irq_vec[FL_WRP];

    // outputs
    assign tio_out = ch_q.tout;
    assign tio_oe  = (ch_q.mode == IO_LOW) || (ch_q.mode == IO_HIGH) ||
                     (ch_q.mode == IO_TGL);

    always_comb begin
        unique case (reg_addr)
            ADR_CTRL: reg_rdata = {{PAD_MODE{1'b0}}, ch_q.mode};
            ADR_IEN:  reg_rdata = {{PAD_IEN{1'b0}}, ch_q.ien};
            ADR_STAT: reg_rdata = {{PAD_STAT{1'b0}}, stat_byte};
            ADR_CNT:  reg_rdata = cnt;
            ADR_GREG: reg_rdata = ch_q.greg;
            default:  reg_rdata = '0;
        endcase
    end

    AST_PIN_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tio_out) |-> $past(hit)); // R3

    AST_GREG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_q.greg) |-> $past(cap_fire || greg_wr)); // R6

endmodule

// File: tb/tmr_chan_top_tb.sv
`timescale 1ns/1ps
module tmr_chan_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] wdata = '0;
    logic        tin = 1'b0;
    logic [15:0] rdata, rdata_n;
    logic        tout, toe, irq_m, irq_w;
    logic        tout_n, toe_n, irqm_n, irqw_n;
    logic        mon_req = 1'b0;
    logic        done = 1'b0;
    int          n_tests = 0;
    int          n_fail = 0;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    tmr_chan_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
        .reg_wdata(wdata), .reg_rdata(rdata), .tio_in(tin), .tio_out(tout),
        .tio_oe(toe), .irq_match(irq_m), .irq_wrap(irq_w)
    );

    tmr_chan_top #(.NO_TOGGLE(1'b1), .STAT_TOP_ONE(1'b0)) u_dut_nt (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
        .reg_wdata(wdata), .reg_rdata(rdata_n), .tio_in(tin), .tio_out(tout_n),
        .tio_oe(toe_n), .irq_match(irqm_n), .irq_wrap(irqw_n)
    );

    // kinds: 0..4 register of u_dut, 5 pin, 6 pin enable, 7 {irq_wrap,irq_match},
    //        8 pin of u_dut_nt, 9 register of u_dut_nt
    task automatic chk(input int kind, input int a, input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        addr = 3'(a);
        rd = (kind < 5) || (kind == 9);
        it.kind = kind; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        mon_req = 1'b1;
        @(posedge clk); #1;
        rd = 1'b0;
        mon_req = 1'b0;
    endtask

    task automatic wreg(input int a, input logic [15:0] d);
        @(negedge clk);
        addr = 3'(a); wdata = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic rd_raw(input int a);
        @(negedge clk);
        addr = 3'(a); rd = 1'b1;
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_tin(input logic v);
        @(negedge clk);
        tin = v;
        @(posedge clk); #1;
    endtask

    task automatic clr_all();
        rd_raw(2);
        wreg(2, 16'h0000);
    endtask

    // monitor: pops expected items as the design presents results
    initial begin
        forever begin
            @(negedge clk); #1;
            if (mon_req) begin
                item_t it;
                logic [15:0] act;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL scoreboard empty");
                end else begin
                    it = exp_q.pop_front();
                    case (it.kind)
                        5:       act = {15'd0, tout};
                        6:       act = {15'd0, toe};
                        7:       act = {14'd0, irq_w, irq_m};
                        8:       act = {15'd0, tout_n};
                        9:       act = rdata_n;
                        default: act = rdata;
                    endcase
                    n_tests++;
                    if (act !== it.exp) begin
                        n_fail++;
                        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(3, 3, 16'h0001, "R1 counter one clock after reset");
        chk(0, 0, 16'h0000, "R1 mode field");
        chk(1, 1, 16'h0000, "R1 enables");
        chk(4, 4, 16'hFFFF, "R1 general register");
        chk(2, 2, 16'h00F8, "R11 status reset default");
        chk(9, 2, 16'h0078, "R11 status reset top bit off");
        chk(5, 0, 16'h0000, "R1 pin level");
        chk(6, 0, 16'h0000, "R1 pin enable");
        chk(7, 0, 16'h0000, "R10 irq idle");

        // R2 counting and load
        wreg(3, 16'h1234);
        chk(3, 3, 16'h1234, "R2 load");
        chk(3, 3, 16'h1235, "R2 step");
        idle(3);
        chk(3, 3, 16'h1239, "R2 steps");

        // R2 wrap, R4 match in mode 000, R10 gating
        wreg(1, 16'h0003);
        wreg(3, 16'hFFFE);
        idle(2);
        chk(7, 0, 16'h0003, "R10 both irq");
        wreg(2, 16'h0000);
        chk(2, 2, 16'h00FB, "R8 unread clear ignored / R2 wrap / R4 flag");
        wreg(2, 16'h00FF);
        chk(2, 2, 16'h00FB, "R8 write one ignored");
        wreg(2, 16'h00FD);
        chk(2, 2, 16'h00F9, "R8 armed clear of wrap flag");
        chk(7, 0, 16'h0001, "R10 match irq only");
        wreg(1, 16'h0000);
        chk(7, 0, 16'h0000, "R10 enable off masks");
        wreg(2, 16'h00FE);
        chk(2, 2, 16'h00F8, "R8 armed clear of match flag");

        // R9 set beats clear
        wreg(4, 16'h0100);
        wreg(3, 16'h0100);
        idle(1);
        chk(2, 2, 16'h00F9, "R4 match flag set");
        wreg(3, 16'h0100);
        wreg(2, 16'h00FE);
        chk(2, 2, 16'h00F9, "R9 set wins over clear");
        wreg(2, 16'h00FE);
        chk(2, 2, 16'h00F8, "R8 clear after re-read");

        // R3 compare output modes, R5 no-toggle variant
        wreg(4, 16'h0200);
        wreg(0, 16'h0002);
        wreg(3, 16'h01FE);
        chk(5, 0, 16'h0000, "R3 pin before match");
        chk(6, 0, 16'h0001, "R3 pin enable mode 010");
        chk(5, 0, 16'h0000, "R3 pin in match cycle");
        chk(5, 0, 16'h0001, "R3 mode 010 drives high");
        chk(8, 0, 16'h0001, "R3 variant mode 010 high");
        wreg(0, 16'h0001);
        wreg(3, 16'h0200);
        chk(5, 0, 16'h0001, "R3 pin in match cycle 001");
        chk(5, 0, 16'h0000, "R3 mode 001 drives low");
        chk(8, 0, 16'h0000, "R3 variant mode 001 low");
        wreg(0, 16'h0003);
        wreg(3, 16'h0200);
        idle(1);
        chk(5, 0, 16'h0001, "R3 toggle to high");
        chk(8, 0, 16'h0001, "R5 forced high");
        wreg(3, 16'h0200);
        idle(1);
        chk(5, 0, 16'h0000, "R3 toggle to low");
        chk(8, 0, 16'h0001, "R5 stays high");
        wreg(0, 16'h0000);
        chk(6, 0, 16'h0000, "R3 pin enable mode 000");
        wreg(3, 16'h0200);
        idle(1);
        chk(5, 0, 16'h0000, "R3 mode 000 holds pin");

        // R6 capture modes
        clr_all();
        wreg(0, 16'h0004);
        wreg(3, 16'h3000);
        set_tin(1'b1);
        idle(2);
        chk(4, 4, 16'h3002, "R6 rising capture");
        chk(2, 2, 16'h00F9, "R6 capture flag");
        clr_all();
        wreg(3, 16'h4000);
        set_tin(1'b0);
        idle(2);
        chk(4, 4, 16'h3002, "R6 falling ignored in 100");
        chk(2, 2, 16'h00F8, "R6 no flag on ignored edge");
        wreg(0, 16'h0005);
        wreg(3, 16'h5000);
        set_tin(1'b1);
        idle(2);
        chk(4, 4, 16'h3002, "R6 rising ignored in 101");
        wreg(3, 16'h5100);
        set_tin(1'b0);
        idle(2);
        chk(4, 4, 16'h5102, "R6 falling capture");
        wreg(0, 16'h0006);
        wreg(3, 16'h6000);
        set_tin(1'b1);
        idle(2);
        chk(4, 4, 16'h6002, "R6 either edge rising");
        wreg(3, 16'h6100);
        set_tin(1'b0);
        idle(2);
        chk(4, 4, 16'h6102, "R6 either edge falling");
        wreg(0, 16'h0007);
        wreg(3, 16'h7000);
        set_tin(1'b1);
        idle(2);
        chk(4, 4, 16'h7002, "R6 mode 111 capture");

        // R7 capture mode ignores match; compare mode ignores edges
        clr_all();
        wreg(3, 16'h7002);
        idle(1);
        chk(2, 2, 16'h00F8, "R7 no match flag in capture mode");
        chk(6, 0, 16'h0000, "R7 pin enable low in capture mode");
        wreg(0, 16'h0002);
        wreg(3, 16'h0010);
        set_tin(1'b0);
        idle(2);
        chk(4, 4, 16'h7002, "R7 edge ignored in compare mode");
        chk(2, 2, 16'h00F8, "R7 no flag from edge in compare mode");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule